// File: doc/BRIEF.md
# SD Card Command Controller (SPI mode)

This block lets a processor drive an SD card in SPI mode through eight byte-wide registers. Software loads a 32-bit argument into four byte registers. It then writes a 6-bit command index, and that write starts the transaction. The controller latches the command and computes the CRC7 over the first 40 frame bits. It then lowers chip select and shifts out the 48-bit frame. Next it clocks idle bytes until the card answers with a one-byte response.

For the single-block read command (index 17) with a clean response, the controller waits for the start-of-data token. It stores the block bytes in an internal buffer and drops the two trailing check bytes. It then raises chip select and gives the card eight more clocks. Software polls a status byte to see when the transaction is finished. It then reads the response byte and takes the block one byte per read from a fixed address. There is no interrupt; the status flag must be polled.

The controller is a single state machine with these states:

- IDLE waits for a trigger.
- LATCH issues the CRC load.
- CRC waits for the CRC result.
- CMD sends the 6 frame bytes.
- RESP waits for the response byte.
- TOKEN waits for the 0xFE token.
- DATA receives the block and its 2 check bytes.
- TAIL sends 8 clocks with chip select high.

Its transitions are:

- IDLE→LATCH on a command write.
- LATCH→CRC always.
- CRC→CMD when the CRC is valid.
- CMD→RESP after the sixth byte.
- RESP→TOKEN on a zero response to index 17.
- RESP→TAIL on any other response or on timeout.
- TOKEN→DATA on 0xFE.
- TOKEN→TAIL on timeout.
- DATA→TAIL after the last check byte.
- TAIL→IDLE after its byte.

Top module: `sdc_cmd_ctrl`

## Requirements
- R1: A write of the command index (bits 5:0) to address 4 while idle starts a transaction. A status read issued in the following cycle shows busy (bit 7) set.
- R2: The frame is sent MSB first as 48 bits: 0, 1, the index, the argument (address 3 = bits 31:24 … address 0 = bits 7:0), the CRC7 with generator x^7+x^3+1 over the first 40 bits, and a final 1. For example, index 0 with argument 0 gives bytes 40 00 00 00 00 95.
- R3: The serial clock idles low and each of its phases lasts HALF system clocks. The data line to the card changes only when the clock falls or while it is low, never while it is high. The data line from the card is sampled when the clock rises.
- R4: Chip select is low from the first frame bit through the last response or block byte. The controller then gives exactly 8 more clock periods with chip select high before returning to idle.
- R5: After the frame, the controller clocks 0xFF bytes until a received byte has MSB 0, and stores it as the response, readable at address 6. If RESP_LIMIT bytes pass without such a byte, the response reads 0xFF.
- R6: For index 17 with a response of 0x00, the controller clocks bytes until 0xFE arrives, giving up after TOKEN_LIMIT bytes. It then stores the next BLK_BYTES bytes, each assembled MSB first, and discards the 2 bytes after them.
- R7: For index 17 with a nonzero response, no token is awaited and the transaction ends right after the response byte.
- R8: Each read of address 5 returns the next stored block byte, starting at the first byte. The read position returns to the first byte when a new block starts and wraps after BLK_BYTES reads.
- R9: Status at address 4 reads {busy, 6'b0, done}. Done is set when a transaction finishes, and any register read clears it after returning it. A second read therefore gives 0x00.
- R10: While busy, writes to every register are ignored. No second transaction starts and the argument registers keep their values.
- R11: After reset, chip select is 1, the serial clock is 0, the data line to the card is 1, and both read data and status are 0x00.
- R12: Read data appears the cycle after the read strobe. Addresses 0–3 return the argument bytes and address 7 returns the command index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| sd_sclk | output | 1 | Serial clock to the card |
| sd_mosi | output | 1 | Serial data to the card |
| sd_miso | input | 1 | Serial data from the card |
| sd_cs_n | output | 1 | Active-low card select |

## Verification
Register results are due one cycle after the read strobe, so the bench raises the strobe on a falling clock edge and samples on the next falling edge. Transaction results (frame, response, buffer, done flag) take a variable number of serial bytes. The bench therefore polls status until busy clears and only then reads them. Serial results are measured as counts of serial clock edges with chip select low or high, taken between the trigger and the end of polling. Data-line timing is watched on every falling system clock edge across the whole run.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_CRC,
        ST_CMD,
        ST_RESP,
        ST_TOKEN,
        ST_DATA,
        ST_TAIL
    } sdc_state_t;

    localparam logic [5:0] IDX_READ_BLOCK = 6'd17;
    localparam logic [7:0] DATA_TOKEN     = 8'hFE;

    localparam logic [2:0] A_ARG0   = 3'd0;
    localparam logic [2:0] A_ARG1   = 3'd1;
    localparam logic [2:0] A_ARG2   = 3'd2;
    localparam logic [2:0] A_ARG3   = 3'd3;
    localparam logic [2:0] A_CMD    = 3'd4;
    localparam logic [2:0] A_BUF    = 3'd5;
    localparam logic [2:0] A_RESP   = 3'd6;
    localparam logic [2:0] A_INDEX  = 3'd7;
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [39:0] msg,
    output logic [6:0]  crc,
    output logic        valid
);
    logic [39:0] sh_q;
    logic [6:0]  crc_q;
    logic [5:0]  cnt_q;
    logic        valid_q;
    logic        fb;

    assign fb = crc_q[6] ^ sh_q[39];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            crc_q   <= '0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            sh_q    <= msg;
            crc_q   <= '0;
            cnt_q   <= 6'd40;
            valid_q <= 1'b0;
        end else if (cnt_q != 6'd0) begin
            crc_q <= {crc_q[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
            sh_q  <= {sh_q[38:0], 1'b0};
            cnt_q <= cnt_q - 6'd1;
            if (cnt_q == 6'd1) valid_q <= 1'b1;
        end
    end

    assign crc   = crc_q;
    assign valid = valid_q;

    // R2
    crc_load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !valid_q);

    // R2
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !load) |=> (valid_q && $stable(crc_q)));
endmodule

// File: rtl/sdc_spi_byte.sv
module sdc_spi_byte #(
    parameter int HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx,
    output logic       sclk,
    output logic       mosi
);
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF - 1);

    logic          active_q, sclk_q, mosi_q, done_q;
    logic [2:0]    bit_q;
    logic [7:0]    tx_sh, rx_sh;
    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            mosi_q   <= 1'b1;
            done_q   <= 1'b0;
            bit_q    <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            div_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !active_q) begin
                active_q <= 1'b1;
                tx_sh    <= tx;
                mosi_q   <= tx[7];
                bit_q    <= 3'd7;
                div_q    <= '0;
            end else if (active_q) begin
                if (div_q == DIV_LAST) begin
                    div_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_sh  <= {rx_sh[6:0], miso};
                    end else begin
                        sclk_q <= 1'b0;
                        if (bit_q == 3'd0) begin
                            active_q <= 1'b0;
                            done_q   <= 1'b1;
                            mosi_q   <= 1'b1;
                        end else begin
                            bit_q  <= bit_q - 3'd1;
                            tx_sh  <= {tx_sh[6:0], 1'b0};
                            mosi_q <= tx_sh[6];
                        end
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    assign busy = active_q;
    assign done = done_q;
    assign rx   = rx_sh;
    assign sclk = sclk_q;
    assign mosi = mosi_q;

    // R3
    mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> $stable(mosi_q));

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active_q) |=> active_q);
endmodule

// File: rtl/sdc_rxbuf.sv
module sdc_rxbuf #(
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sdc_cmd_ctrl.sv
module sdc_cmd_ctrl
    import sdc_pkg::*;
#(
    parameter int HALF        = 4,
    parameter int BLK_BYTES   = 512,
    parameter int RESP_LIMIT  = 16,
    parameter int TOKEN_LIMIT = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       sd_sclk,
    output logic       sd_mosi,
    input  logic       sd_miso,
    output logic       sd_cs_n
);
    localparam int M1   = (BLK_BYTES + 2 > RESP_LIMIT) ? BLK_BYTES + 2 : RESP_LIMIT;
    localparam int MAXC = (M1 > TOKEN_LIMIT) ? M1 : TOKEN_LIMIT;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int AW   = $clog2(BLK_BYTES);
    localparam logic [CW-1:0] CMD_LAST  = CW'(5);
    localparam logic [CW-1:0] RESP_LAST = CW'(RESP_LIMIT - 1);
    localparam logic [CW-1:0] TOK_LAST  = CW'(TOKEN_LIMIT - 1);
    localparam logic [CW-1:0] DATA_LAST = CW'(BLK_BYTES + 1);
    localparam logic [CW-1:0] BLK_CNT   = CW'(BLK_BYTES);
    localparam logic [AW-1:0] PTR_LAST  = AW'(BLK_BYTES - 1);

    sdc_state_t    state_q, state_d;
    logic [5:0]    cmd_q;
    logic [31:0]   arg_q;
    logic [47:0]   frame_q;
    logic [CW-1:0] cnt_q;
    logic [7:0]    r1_q, rdata_q;
    logic          flag_q;
    logic [AW-1:0] rd_ptr_q;

    logic          busy, acc_wr, is_read, finish;
    logic          cs_n_c, crc_load, xfer;
    logic [7:0]    eng_tx, eng_rx, buf_rdata;
    logic          eng_start, eng_busy, eng_done;
    logic [6:0]    crc_val;
    logic          crc_valid, buf_we;

    assign busy    = (state_q != ST_IDLE);
    assign acc_wr  = bus_wr && !busy;
    assign is_read = (cmd_q == IDX_READ_BLOCK);
    assign finish  = (state_q == ST_TAIL) && eng_done;

    sdc_crc7 u_crc (
        .clk(clk), .rst_n(rst_n), .load(crc_load),
        .msg({2'b01, cmd_q, arg_q}), .crc(crc_val), .valid(crc_valid)
    );

    sdc_spi_byte #(.HALF(HALF)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .tx(eng_tx), .miso(sd_miso),
        .busy(eng_busy), .done(eng_done), .rx(eng_rx), .sclk(sd_sclk), .mosi(sd_mosi)
    );

    sdc_rxbuf #(.DEPTH(BLK_BYTES), .AW(AW)) u_buf (
        .clk(clk), .we(buf_we), .waddr(cnt_q[AW-1:0]), .wdata(eng_rx),
        .raddr(rd_ptr_q), .rdata(buf_rdata)
    );

    assign eng_start = xfer && !eng_busy && !eng_done;
    assign buf_we    = (state_q == ST_DATA) && eng_done && (cnt_q < BLK_CNT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (acc_wr && bus_addr == A_CMD) state_d = ST_LATCH;
            ST_LATCH: state_d = ST_CRC;
            ST_CRC:   if (crc_valid) state_d = ST_CMD;
            ST_CMD:   if (eng_done && cnt_q == CMD_LAST) state_d = ST_RESP;
            ST_RESP:
                if (eng_done) begin
                    if (!eng_rx[7])
                        state_d = (is_read && eng_rx == 8'h00) ? ST_TOKEN : ST_TAIL;
                    else if (cnt_q == RESP_LAST)
                        state_d = ST_TAIL;
                end
            ST_TOKEN:
                if (eng_done) begin
                    if (eng_rx == DATA_TOKEN)   state_d = ST_DATA;
                    else if (cnt_q == TOK_LAST) state_d = ST_TAIL;
                end
            ST_DATA:  if (eng_done && cnt_q == DATA_LAST) state_d = ST_TAIL;
            ST_TAIL:  if (eng_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        cs_n_c   = 1'b1;
        crc_load = 1'b0;
        xfer     = 1'b0;
        eng_tx   = 8'hFF;
        unique case (state_q)
            ST_IDLE, ST_CRC: ;
            ST_LATCH: crc_load = 1'b1;
            ST_CMD: begin
                cs_n_c = 1'b0;
                xfer   = 1'b1;
                eng_tx = frame_q[47:40];
            end
            ST_RESP, ST_TOKEN, ST_DATA: begin
                cs_n_c = 1'b0;
                xfer   = 1'b1;
            end
            ST_TAIL:  xfer = 1'b1;
            default: ;
        endcase
    end

    assign sd_cs_n   = cs_n_c;
    assign bus_rdata = rdata_q;

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            arg_q    <= '0;
            frame_q  <= '0;
            cnt_q    <= '0;
            r1_q     <= '0;
            flag_q   <= 1'b0;
            rd_ptr_q <= '0;
            rdata_q  <= '0;
        end else begin
            if (acc_wr) begin
                case (bus_addr)
                    A_ARG0:  arg_q[7:0]   <= bus_wdata;
                    A_ARG1:  arg_q[15:8]  <= bus_wdata;
                    A_ARG2:  arg_q[23:16] <= bus_wdata;
                    A_ARG3:  arg_q[31:24] <= bus_wdata;
                    A_CMD:   cmd_q        <= bus_wdata[5:0];
                    default: ;
                endcase
            end

            if (state_d != state_q) cnt_q <= '0;
            else if (eng_done)      cnt_q <= cnt_q + 1'b1;

            if (state_q == ST_CRC && crc_valid)
                frame_q <= {2'b01, cmd_q, arg_q, crc_val, 1'b1};
            else if (state_q == ST_CMD && eng_done)
                frame_q <= {frame_q[39:0], 8'hFF};

            if (state_q == ST_RESP && eng_done) begin
                if (!eng_rx[7])              r1_q <= eng_rx;
                else if (cnt_q == RESP_LAST) r1_q <= 8'hFF;
            end

            if (finish)      flag_q <= 1'b1;
            else if (bus_rd) flag_q <= 1'b0;

            if (state_q == ST_TOKEN && eng_done && eng_rx == DATA_TOKEN)
                rd_ptr_q <= '0;
            else if (bus_rd && bus_addr == A_BUF)
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;

            if (bus_rd) begin
                case (bus_addr)
                    A_ARG0:  rdata_q <= arg_q[7:0];
                    A_ARG1:  rdata_q <= arg_q[15:8];
                    A_ARG2:  rdata_q <= arg_q[23:16];
                    A_ARG3:  rdata_q <= arg_q[31:24];
                    A_CMD:   rdata_q <= {busy, 6'b0, flag_q};
                    A_BUF:   rdata_q <= buf_rdata;
                    A_RESP:  rdata_q <= r1_q;
                    default: rdata_q <= {2'b00, cmd_q};
                endcase
            end
        end
    end

    // R1
    trigger_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CMD && state_q == ST_IDLE) |=> (crc_load ##1 !crc_valid));

    // R10
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr) |=> ($stable(arg_q) && $stable(cmd_q)));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !finish) |=> !flag_q);

    // R4
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_cs_n) |-> !eng_busy);
endmodule

// File: tb/tb_sdc_cmd_ctrl.sv
module tb_sdc_cmd_ctrl;
    localparam int HALF = 2;
    localparam int BLK  = 4;
    localparam int RLIM = 8;
    localparam int TLIM = 6;

    // cmd[57:52] arg[51:20] r1[19:12] gap[11:8] last_byte[7:0]
    localparam logic [57:0] VEC [0:4] = '{
        {6'd0,  32'h0000_0000, 8'h01, 4'd1, 8'h95},
        {6'd8,  32'h0000_01AA, 8'h01, 4'd2, 8'h87},
        {6'd55, 32'h0000_0000, 8'h01, 4'd0, 8'h65},
        {6'd41, 32'h4000_0000, 8'h00, 4'd3, 8'h77},
        {6'd58, 32'h0000_0000, 8'h00, 4'd0, 8'hFD}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sd_sclk, sd_mosi, sd_cs_n;
    logic       miso_r = 1'b1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sdc_cmd_ctrl #(.HALF(HALF), .BLK_BYTES(BLK), .RESP_LIMIT(RLIM), .TOKEN_LIMIT(TLIM)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sd_sclk(sd_sclk), .sd_mosi(sd_mosi),
        .sd_miso(miso_r), .sd_cs_n(sd_cs_n)
    );

    // card model
    logic [7:0]  stream [32];
    logic [47:0] cmd_sh = '0;
    logic [47:0] last_frame = '0;
    int k = 0;
    int rises_low = 0;
    int rises_high = 0;
    int frames = 0;
    int half_viol = 0;
    int mosi_viol = 0;
    realtime t_rise = 0;
    logic mosi_p = 1'b1;

    function automatic logic card_bit(int kk);
        int idx;
        idx = kk / 8;
        if (idx < 6 || idx - 6 >= 32) return 1'b1;
        return stream[idx - 6][7 - (kk % 8)];
    endfunction

    always @(posedge sd_sclk) begin
        t_rise = $realtime;
        if (!sd_cs_n) begin
            cmd_sh = {cmd_sh[46:0], sd_mosi};
            k = k + 1;
            rises_low = rises_low + 1;
            if (k == 48) last_frame = cmd_sh;
        end else begin
            rises_high = rises_high + 1;
            k = 0;
        end
    end

    always @(negedge sd_sclk) begin
        if ($realtime - t_rise != HALF * 8.0) half_viol = half_viol + 1;
        if (!sd_cs_n) miso_r <= card_bit(k);
        else          miso_r <= 1'b1;
    end

    always @(negedge sd_cs_n) frames = frames + 1;

    always @(negedge clk) begin
        if (rst_n && sd_sclk && sd_mosi !== mosi_p) mosi_viol = mosi_viol + 1;
        mosi_p = sd_mosi;
    end

    function automatic logic [6:0] ref_crc(input logic [39:0] m);
        logic [46:0] r;
        r = {m, 7'b0};
        for (int i = 46; i >= 7; i--)
            if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
        return r[6:0];
    endfunction

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic fill_idle();
        for (int i = 0; i < 32; i++) stream[i] = 8'hFF;
    endtask

    task automatic issue(input logic [5:0] cmd, input logic [31:0] arg);
        logic [7:0] st;
        bus_write(3'd0, arg[7:0]);
        bus_write(3'd1, arg[15:8]);
        bus_write(3'd2, arg[23:16]);
        bus_write(3'd3, arg[31:24]);
        bus_write(3'd4, {2'b00, cmd});
        bus_read(3'd4, st);
        check("R1 busy after trigger", 48'(st), 48'h80);
    endtask

    task automatic wait_done(output logic [7:0] st);
        int n;
        n = 0;
        do begin
            bus_read(3'd4, st);
            n++;
        end while (st[7] && n < 20000);
    endtask

    task automatic run_all();
        logic [7:0]  d, st;
        logic [57:0] v;
        logic [39:0] head;
        int rl0, rh0, f0;

        // R11 reset state
        repeat (4) @(negedge clk);
        check("R11 cs_n at reset", 48'(sd_cs_n), 48'h1);
        check("R11 sclk at reset", 48'(sd_sclk), 48'h0);
        check("R11 mosi at reset", 48'(sd_mosi), 48'h1);
        check("R11 rdata at reset", 48'(bus_rdata), 48'h0);
        rst_n = 1'b1;
        bus_read(3'd4, d);
        check("R11 status after reset", 48'(d), 48'h0);

        // vector table: R2 R4 R5 R9
        for (int i = 0; i < 5; i++) begin
            v = VEC[i];
            fill_idle();
            stream[int'(v[11:8])] = v[19:12];
            rl0 = rises_low; rh0 = rises_high;
            issue(v[57:52], v[51:20]);
            wait_done(st);
            check("R9 done flag set", 48'(st), 48'h01);
            check("R2 frame", last_frame, {2'b01, v[57:52], v[51:20], v[7:0]});
            bus_read(3'd6, d);
            check("R5 response byte", 48'(d), 48'(v[19:12]));
            check("R4 clocks with cs low", 48'(rises_low - rl0), 48'(8 * (7 + int'(v[11:8]))));
            check("R4 tail clocks", 48'(rises_high - rh0), 48'd8);
        end
        bus_read(3'd4, d);
        check("R9 flag cleared by read", 48'(d), 48'h0);

        // R12 readback
        bus_read(3'd3, d);
        check("R12 arg byte 3 readback", 48'(d), 48'h00);
        bus_read(3'd7, d);
        check("R12 index readback", 48'(d), 48'd58);

        // R6 single-block read
        fill_idle();
        stream[1] = 8'h00; stream[4] = 8'hFE;
        stream[5] = 8'hDE; stream[6] = 8'hAD; stream[7] = 8'hBE; stream[8] = 8'hEF;
        stream[9] = 8'hC1; stream[10] = 8'hC2;
        rl0 = rises_low;
        head = {2'b01, 6'd17, 32'h0000_0400};
        issue(6'd17, 32'h0000_0400);
        wait_done(st);
        check("R2 frame for block read", last_frame, {head, ref_crc(head), 1'b1});
        check("R6 clocks through block", 48'(rises_low - rl0), 48'(8 * 17));
        bus_read(3'd5, d); check("R6 block byte 0", 48'(d), 48'hDE);
        bus_read(3'd5, d); check("R6 block byte 1", 48'(d), 48'hAD);
        bus_read(3'd5, d); check("R6 block byte 2", 48'(d), 48'hBE);
        bus_read(3'd5, d); check("R6 block byte 3", 48'(d), 48'hEF);
        bus_read(3'd5, d); check("R8 read position wraps", 48'(d), 48'hDE);

        // R8 new block restarts the read position
        fill_idle();
        stream[0] = 8'h00; stream[1] = 8'hFE;
        stream[2] = 8'h11; stream[3] = 8'h22; stream[4] = 8'h33; stream[5] = 8'h44;
        issue(6'd17, 32'h0);
        wait_done(st);
        bus_read(3'd5, d); check("R8 first byte of new block", 48'(d), 48'h11);

        // R7 error response on block read
        fill_idle();
        stream[0] = 8'h05; stream[1] = 8'hFE; stream[2] = 8'h99;
        rl0 = rises_low;
        issue(6'd17, 32'h0);
        wait_done(st);
        bus_read(3'd6, d);
        check("R7 error response kept", 48'(d), 48'h05);
        check("R7 no token wait", 48'(rises_low - rl0), 48'(8 * 7));
        bus_read(3'd5, d);
        check("R7 buffer untouched", 48'(d), 48'h22);

        // R5 response timeout
        fill_idle();
        rl0 = rises_low;
        issue(6'd0, 32'h0);
        wait_done(st);
        bus_read(3'd6, d);
        check("R5 timeout response", 48'(d), 48'hFF);
        check("R5 timeout length", 48'(rises_low - rl0), 48'(8 * (6 + RLIM)));

        // R6 token timeout
        fill_idle();
        stream[0] = 8'h00;
        rl0 = rises_low;
        issue(6'd17, 32'h0);
        wait_done(st);
        check("R6 token timeout length", 48'(rises_low - rl0), 48'(8 * (7 + TLIM)));

        // R10 writes while busy
        fill_idle();
        stream[0] = 8'h01;
        f0 = frames;
        issue(6'd55, 32'h0);
        bus_write(3'd0, 8'hAA);
        bus_write(3'd4, 8'h11);
        wait_done(st);
        repeat (200) @(negedge clk);
        check("R10 one transaction only", 48'(frames - f0), 48'd1);
        bus_read(3'd0, d);
        check("R10 argument unchanged", 48'(d), 48'h00);
        bus_read(3'd7, d);
        check("R10 index unchanged", 48'(d), 48'd55);

        // R3 serial timing across the run
        check("R3 data line changed while clock high", 48'(mosi_viol), 48'd0);
        check("R3 half period length", 48'(half_viol), 48'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog R1 actual=hung expected=complete");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule